// File: doc/BRIEF.md
# Multi-Format Multiply-Accumulate Unit

This block multiplies two 16-bit operands and loads, adds or subtracts the product into a 40-bit accumulator. The operands can be read in one of three number formats: unsigned fraction, signed fraction or signed integer. The format sets how the raw product is corrected and widened to 40 bits. It also sets the bounds at which the accumulator clamps.

Each operation takes one clock edge. The result is always saturated to the range of the current format, and a sticky flag records that a clamp has happened. A synchronous clear zeroes the accumulator and the flag. Extraction of a narrower result from the accumulator is done by logic outside this block.

Top module: `mac_unit`

## Requirements
- R1: After reset, `acc` is zero and `ovf` is low.
- R2: With `mode` = 0 (unsigned fraction), the operands are unsigned and the 32-bit product is not shifted. It is zero-extended to 40 bits, so 0x8000 times 0x8000 loads 0x00_4000_0000.
- R3: With `mode` = 1 (signed fraction), the signed product is shifted left one place and sign-extended to 40 bits. The single case 0x8000 times 0x8000 gives 0x00_7FFF_FFFF.
- R4: With `mode` = 2 (signed integer), the signed product is sign-extended to 40 bits with no shift. `mode` = 3 behaves as `mode` = 2.
- R5: `op` = 0 loads the extended product, `op` = 1 adds it to the accumulator and `op` = 2 subtracts it from the accumulator. `op` = 3 behaves as a load.
- R6: In `mode` 0 the accumulator is read as unsigned, and any result is clamped to the range 0x00_0000_0000 to 0xFF_FFFF_FFFF.
- R7: In modes 1 to 3 the accumulator is read as two's complement, and any result is clamped to the range 0x80_0000_0000 to 0x7F_FFFF_FFFF.
- R8: `ovf` is set on any update that clamps, and it stays set until a clear or a reset.
- R9: `clr` high at a clock edge zeroes `acc` and `ovf`, even when `valid` is also high.
- R10: With `valid` low and `clr` low, `acc` and `ovf` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of accumulator and flag |
| valid | input | 1 | Perform an operation at this edge |
| mode | input | 2 | Number format: 0 unsigned fraction, 1 signed fraction, 2 or 3 signed integer |
| op | input | 2 | Action: 0 load, 1 add, 2 subtract, 3 load |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| acc | output | 40 | Registered accumulator |
| ovf | output | 1 | Sticky saturation flag |

## Verification
Directed cases apply 0x8000 times 0x8000 in every format. This separates the plain unsigned product, the forced signed-fraction maximum and the unshifted integer product. Long runs of full-scale adds and subtracts drive the accumulator into each clamp bound, and show whether the guard bits stop a wrapped sum from being stored and whether the flag stays set. Seeded random operands, formats and actions, including the alias codes, mixed with random clears and idle cycles, are compared against a bench model of the same arithmetic.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OPND_W = 16;
    localparam int ACCU_W = 40;

    typedef enum logic [1:0] {
        FMT_UFRAC = 2'd0,
        FMT_SFRAC = 2'd1,
        FMT_SINT  = 2'd2,
        FMT_SINT2 = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ACT_LOAD  = 2'd0,
        ACT_ADD   = 2'd1,
        ACT_SUB   = 2'd2,
        ACT_LOAD2 = 2'd3
    } act_e;

    function automatic logic is_unsigned(input fmt_e f);
        return f == FMT_UFRAC;
    endfunction

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int OP_W  = OPND_W,
    parameter int ACC_W = ACCU_W
) (
    input  logic [OP_W-1:0]  opa,
    input  logic [OP_W-1:0]  opb,
    input  fmt_e             fmt,
    output logic [ACC_W-1:0] ext_prod
);
    localparam int PW  = 2 * OP_W;
    localparam int EXT = ACC_W - PW;
    localparam logic [OP_W-1:0] MOST_NEG = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic [PW-1:0]   FRAC_MAX = {1'b0, {(PW-1){1'b1}}};

    logic [PW-1:0]        u_raw;
    logic signed [PW-1:0] s_raw;
    logic [PW-1:0]        frac_p;
    logic                 corner;

    assign u_raw  = opa * opb;
    assign s_raw  = $signed(opa) * $signed(opb);
    assign corner = (opa == MOST_NEG) && (opb == MOST_NEG);
    assign frac_p = corner ? FRAC_MAX : {s_raw[PW-2:0], 1'b0};

    always_comb begin
        case (fmt)
            FMT_UFRAC: ext_prod = {{EXT{1'b0}}, u_raw};
            FMT_SFRAC: ext_prod = {{EXT{frac_p[PW-1]}}, frac_p};
            default:   ext_prod = {{EXT{s_raw[PW-1]}}, s_raw};
        endcase
    end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
    import mac_pkg::*;
#(
    parameter int ACC_W = ACCU_W,
    parameter int GUARD = 2
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] prod_in,
    input  fmt_e             fmt,
    input  act_e             act,
    output logic [ACC_W-1:0] res,
    output logic             clip
);
    localparam int WIDE = ACC_W + GUARD;

    localparam logic signed [WIDE-1:0] U_HI = {{GUARD{1'b0}}, {ACC_W{1'b1}}};
    localparam logic signed [WIDE-1:0] U_LO = '0;
    localparam logic signed [WIDE-1:0] S_HI = {{(GUARD+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [WIDE-1:0] S_LO = {{(GUARD+1){1'b1}}, {(ACC_W-1){1'b0}}};

    logic signed [WIDE-1:0] acc_w, prod_w, sum_w, hi, lo;
    logic                   uns;

    assign uns    = is_unsigned(fmt);
    assign acc_w  = uns ? {{GUARD{1'b0}}, acc_in}  : {{GUARD{acc_in[ACC_W-1]}}, acc_in};
    assign prod_w = uns ? {{GUARD{1'b0}}, prod_in} : {{GUARD{prod_in[ACC_W-1]}}, prod_in};
    assign hi     = uns ? U_HI : S_HI;
    assign lo     = uns ? U_LO : S_LO;

    always_comb begin
        case (act)
            ACT_ADD: sum_w = acc_w + prod_w;
            ACT_SUB: sum_w = acc_w - prod_w;
            default: sum_w = prod_w;
        endcase
        if (sum_w > hi) begin
            res  = hi[ACC_W-1:0];
            clip = 1'b1;
        end else if (sum_w < lo) begin
            res  = lo[ACC_W-1:0];
            clip = 1'b1;
        end else begin
            res  = sum_w[ACC_W-1:0];
            clip = 1'b0;
        end
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int OP_W  = OPND_W,
    parameter int ACC_W = ACCU_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             valid,
    input  logic [1:0]       mode,
    input  logic [1:0]       op,
    input  logic [OP_W-1:0]  a,
    input  logic [OP_W-1:0]  b,
    output logic [ACC_W-1:0] acc,
    output logic             ovf
);
    fmt_e             fmt;
    act_e             act;
    logic [ACC_W-1:0] ext_prod, next_acc;
    logic             clip;
    logic [ACC_W-1:0] acc_q;
    logic             ovf_q;

    assign fmt = fmt_e'(mode);
    assign act = act_e'(op);

    mac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
        .opa(a), .opb(b), .fmt(fmt), .ext_prod(ext_prod)
    );

    mac_saturate #(.ACC_W(ACC_W), .GUARD(2)) u_sat (
        .acc_in(acc_q), .prod_in(ext_prod), .fmt(fmt), .act(act),
        .res(next_acc), .clip(clip)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (valid) begin
            acc_q <= next_acc;
            ovf_q <= ovf_q | clip;
        end
    end

    assign acc = acc_q;
    assign ovf = ovf_q;

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0) && !ovf_q);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid && !clr) |=> $stable(acc_q) && $stable(ovf_q));

    // R8
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr) |=> ovf_q);

    // R8
    clip_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !clr && clip) |=> ovf_q);

    // R5
    load_takes_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !clr && (op == 2'd0 || op == 2'd3)) |=> acc_q == $past(ext_prod));
endmodule

// File: tb/mac_unit_test.sv
module mac_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, clr, valid;
    logic [1:0]  mode, op;
    logic [15:0] a, b;
    logic [39:0] acc;
    logic        ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [39:0] m_acc;
    logic        m_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_unit uut (
        .clk(clk), .rst(rst), .clr(clr), .valid(valid), .mode(mode), .op(op),
        .a(a), .b(b), .acc(acc), .ovf(ovf)
    );

    function automatic longint ref_prod(input logic [1:0] md, input logic [15:0] x, input logic [15:0] y);
        longint sx, sy;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        if (md == 2'd0) return longint'(x) * longint'(y);
        if (md == 2'd1) begin
            if (x == 16'h8000 && y == 16'h8000) return 64'sh7FFF_FFFF;
            return sx * sy * 2;
        end
        return sx * sy;
    endfunction

    task automatic ref_step(input logic [1:0] md, input logic [1:0] o, input logic [15:0] x, input logic [15:0] y);
        longint cur, p, r, hi, lo;
        p = ref_prod(md, x, y);
        if (md == 2'd0) begin
            cur = longint'(m_acc);
            hi  = 64'sh00FF_FFFF_FFFF;
            lo  = 0;
        end else begin
            cur = m_acc[39] ? longint'(m_acc) - 64'sh0100_0000_0000 : longint'(m_acc);
            hi  = 64'sh007F_FFFF_FFFF;
            lo  = -64'sh0080_0000_0000;
        end
        case (o)
            2'd1: r = cur + p;
            2'd2: r = cur - p;
            default: r = p;
        endcase
        if (r > hi) begin r = hi; m_ovf = 1'b1; end
        else if (r < lo) begin r = lo; m_ovf = 1'b1; end
        m_acc = r[39:0];
    endtask

    task automatic compare(input string req);
        n_chk++;
        if (acc !== m_acc || ovf !== m_ovf) begin
            n_bad++;
            $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b", req, acc, ovf, m_acc, m_ovf);
        end
    endtask

    task automatic step(input string req, input logic v, input logic c,
                        input logic [1:0] md, input logic [1:0] o,
                        input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        valid = v; clr = c; mode = md; op = o; a = x; b = y;
        @(posedge clk);
        #1;
        if (c) begin m_acc = '0; m_ovf = 1'b0; end
        else if (v) ref_step(md, o, x, y);
        compare(req);
    endtask

    initial begin
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        rst = 1'b1; clr = 1'b0; valid = 1'b0; mode = '0; op = '0; a = '0; b = '0;
        m_acc = '0; m_ovf = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset");
        @(negedge clk);
        rst = 1'b0;

        // R2 corner load, unsigned
        step("R2", 1, 0, 2'd0, 2'd0, 16'h8000, 16'h8000);
        if (acc !== 40'h00_4000_0000) begin n_bad++; $display("FAIL R2: acc=%h expected 0040000000", acc); end
        n_chk++;
        // R3 forced maximum
        step("R3", 1, 0, 2'd1, 2'd0, 16'h8000, 16'h8000);
        if (acc !== 40'h00_7FFF_FFFF) begin n_bad++; $display("FAIL R3: acc=%h expected 007FFFFFFF", acc); end
        n_chk++;
        step("R3 negative", 1, 0, 2'd1, 2'd0, 16'h8000, 16'h4000);
        // R4 integer and alias
        step("R4", 1, 0, 2'd2, 2'd0, 16'h8000, 16'h8000);
        step("R4 alias", 1, 0, 2'd3, 2'd0, 16'hFFFF, 16'h0003);
        // R5 actions
        step("R5 add", 1, 0, 2'd2, 2'd1, 16'h0100, 16'h0010);
        step("R5 sub", 1, 0, 2'd2, 2'd2, 16'h0200, 16'h0010);
        step("R5 load alias", 1, 0, 2'd2, 2'd3, 16'h0007, 16'h0009);
        // R10 idle
        step("R10", 0, 0, 2'd0, 2'd1, 16'hFFFF, 16'hFFFF);
        // R6 unsigned upper clamp
        step("R9", 0, 1, 2'd0, 2'd0, 0, 0);
        for (int i = 0; i < 260; i++) step("R6 upper", 1, 0, 2'd0, 2'd1, 16'hFFFF, 16'hFFFF);
        step("R6 lower", 1, 0, 2'd0, 2'd0, 16'h0001, 16'h0001);
        step("R6 lower", 1, 0, 2'd0, 2'd2, 16'h0002, 16'h0002);
        step("R8 sticky", 1, 0, 2'd0, 2'd0, 16'h0003, 16'h0003);
        // R9 clear over valid
        step("R9 priority", 1, 1, 2'd0, 2'd1, 16'hFFFF, 16'hFFFF);
        // R7 signed clamps
        for (int i = 0; i < 515; i++) step("R7 upper", 1, 0, 2'd2, 2'd1, 16'h8000, 16'h8000);
        step("R9", 0, 1, 2'd0, 2'd0, 0, 0);
        for (int i = 0; i < 515; i++) step("R7 lower", 1, 0, 2'd2, 2'd2, 16'h8000, 16'h8000);
        step("R10 hold", 0, 0, 2'd1, 2'd1, 16'h1234, 16'h5678);
        step("R9", 0, 1, 2'd0, 2'd0, 0, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic v, c;
            v = ($urandom % 8) != 0;
            c = ($urandom % 64) == 0;
            step("R5 random", v, c, 2'($urandom), 2'($urandom), 16'($urandom), 16'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule